// File: doc/BRIEF.md
# Single-Step Integer Execute Stage

This block executes one 32-bit instruction word of a classic three-format RISC instruction set in a single combinational step. The caller reads the two source registers elsewhere and presents them as `opa` and `opb`. It also presents the current program counter and, for loads, the word returned by memory. From these the block forms the value to write back and the address of the next instruction. It also forms the read and write requests that go to the data memory.

The block holds no state and has no clock. A surrounding core owns the register file, instruction fetch and data memory. That core uses the outputs of this block as the next values of its own registers. The block handles a fixed subset of operations: register ALU operations, immediate ALU operations, signed compares, arithmetic right shift, conditional branches, absolute and register jumps, and word load and store. It does not trap on overflow and has no delay slot.

Top module: `exec_comb_unit`

## Requirements
- R1: With opcode bits [31:26]=0x00, function bits [5:0]=0x20 gives result = opa+opb, and 0x22 gives result = opa-opb. Both wrap modulo 2^32.
- R2: With opcode 0x00, function 0x24 gives bitwise AND of opa and opb, 0x25 gives OR, 0x26 gives XOR and 0x27 gives NOR.
- R3: Function 0x2A (opcode 0x00) and opcode 0x0A compare opa as a signed value, against opb and against the sign-extended immediate [15:0] respectively. The result is 1 when opa is smaller and 0 otherwise.
- R4: Function 0x03 (opcode 0x00) gives result = opb shifted right arithmetically by bits [10:6].
- R5: Opcode 0x08 adds opa and the sign-extended immediate. Opcode 0x0C ANDs opa with the zero-extended immediate, and opcode 0x0E XORs opa with it.
- R6: Opcode 0x04 (taken when opa==opb) and opcode 0x05 (taken when opa!=opb) set pc_next = pc+4+(sign-extended immediate << 2) when taken and pc+4 otherwise.
- R7: Opcode 0x07 is taken only when opa is strictly positive as a signed value. Zero and values with bit 31 set are not taken. Its target is computed as in R6.
- R8: Opcode 0x02 sets pc_next = {(pc+4)[31:28], insn[25:0], 2'b00}. Opcode 0x00 with function 0x08 sets pc_next = opa.
- R9: Opcode 0x23 raises rd_en and sets rd_addr = opa + sign-extended immediate, result = rd_data and wr_en = 0.
- R10: Opcode 0x2B raises wr_en and sets wr_addr = opa + sign-extended immediate, wr_data = opb, rd_en = 0 and result = 0.
- R11: For every instruction other than 0x23 and 0x2B, both enables are 0. Whenever its enable is low, each of rd_addr, wr_addr and wr_data is 0. Every ALU, immediate, load and store operation sets pc_next = pc+4.
- R12: An unrecognised opcode, or opcode 0x00 with an unlisted function, gives result = 0, both enables 0 and pc_next = pc+4.
- R13: Branches, jumps and stores give result = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word being executed |
| pc_cur | input | 32 | Address of that instruction |
| opa | input | 32 | First source register value |
| opb | input | 32 | Second source register value |
| rd_data | input | 32 | Word returned by data memory for a load |
| rd_addr | output | 32 | Load address |
| rd_en | output | 1 | Load request |
| wr_data | output | 32 | Store data |
| wr_addr | output | 32 | Store address |
| wr_en | output | 1 | Store request |
| result | output | 32 | Value to write back |
| pc_next | output | 32 | Address of the next instruction |

## Verification
The hardest cases to reach are the edges of the signed decisions. One is bgtz seeing exactly zero, 0x80000000 or 0x7FFFFFFF. Another is a signed compare whose operands differ in sign while their unsigned order is the reverse. A third is a branch offset that is negative and carries the target below pc. Random words rarely hit these, so directed vectors place these operand values and offsets on purpose. A long random run then mixes every listed encoding with arbitrary words, which exercises the unrecognised-encoding path and the idle state of the memory strobes.

// File: rtl/exec_pkg.sv
package exec_pkg;
    localparam int XLEN    = 32;
    localparam int OPC_W   = 6;
    localparam int IMM_W   = 16;
    localparam int TGT_W   = 26;
    localparam int SHAMT_W = 5;
    localparam int PC_STEP = 4;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OPC_JABS  = 6'h02;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BNE   = 6'h05;
    localparam logic [OPC_W-1:0] OPC_BGTZ  = 6'h07;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'h0A;
    localparam logic [OPC_W-1:0] OPC_ANDI  = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_XORI  = 6'h0E;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;

    localparam logic [OPC_W-1:0] FN_SRA  = 6'h03;
    localparam logic [OPC_W-1:0] FN_JREG = 6'h08;
    localparam logic [OPC_W-1:0] FN_ADD  = 6'h20;
    localparam logic [OPC_W-1:0] FN_SUB  = 6'h22;
    localparam logic [OPC_W-1:0] FN_AND  = 6'h24;
    localparam logic [OPC_W-1:0] FN_OR   = 6'h25;
    localparam logic [OPC_W-1:0] FN_XOR  = 6'h26;
    localparam logic [OPC_W-1:0] FN_NOR  = 6'h27;
    localparam logic [OPC_W-1:0] FN_SLT  = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_SLT, ALU_SRA
    } alu_op_e;

    typedef enum logic [1:0] {
        OPB_REG, OPB_SEXT, OPB_ZEXT
    } opb_sel_e;

    typedef enum logic [2:0] {
        NPC_SEQ, NPC_EQ, NPC_NE, NPC_GTZ, NPC_JABS, NPC_JREG
    } npc_sel_e;

    typedef enum logic [1:0] {
        RES_NONE, RES_ALU, RES_LOAD
    } res_sel_e;

    typedef struct packed {
        alu_op_e  alu_op;
        opb_sel_e opb_sel;
        npc_sel_e npc_sel;
        res_sel_e res_sel;
        logic     mem_rd;
        logic     mem_wr;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] rd_addr;
        logic            rd_en;
        logic [XLEN-1:0] wr_data;
        logic [XLEN-1:0] wr_addr;
        logic            wr_en;
        logic [XLEN-1:0] result;
    } exec_out_t;
endpackage

// File: rtl/exec_decode.sv
module exec_decode
    import exec_pkg::*;
(
    input  logic [XLEN-1:0] insn,
    output ctrl_t           ctrl_d
);
    logic [OPC_W-1:0] opc;
    logic [OPC_W-1:0] fn;

    assign opc = insn[XLEN-1 -: OPC_W];
    assign fn  = insn[OPC_W-1:0];

    always_comb begin
        ctrl_d = '{alu_op: ALU_ADD, opb_sel: OPB_REG, npc_sel: NPC_SEQ,
                   res_sel: RES_NONE, mem_rd: 1'b0, mem_wr: 1'b0};
        unique case (opc)
            OPC_RTYPE: begin
                ctrl_d.res_sel = RES_ALU;
                unique case (fn)
                    FN_ADD:  ctrl_d.alu_op = ALU_ADD;
                    FN_SUB:  ctrl_d.alu_op = ALU_SUB;
                    FN_AND:  ctrl_d.alu_op = ALU_AND;
                    FN_OR:   ctrl_d.alu_op = ALU_OR;
                    FN_XOR:  ctrl_d.alu_op = ALU_XOR;
                    FN_NOR:  ctrl_d.alu_op = ALU_NOR;
                    FN_SLT:  ctrl_d.alu_op = ALU_SLT;
                    FN_SRA:  ctrl_d.alu_op = ALU_SRA;
                    FN_JREG: begin
                        ctrl_d.res_sel = RES_NONE;
                        ctrl_d.npc_sel = NPC_JREG;
                    end
                    default: ctrl_d.res_sel = RES_NONE;
                endcase
            end
            OPC_ADDI: begin
                ctrl_d.opb_sel = OPB_SEXT;
                ctrl_d.res_sel = RES_ALU;
            end
            OPC_SLTI: begin
                ctrl_d.alu_op  = ALU_SLT;
                ctrl_d.opb_sel = OPB_SEXT;
                ctrl_d.res_sel = RES_ALU;
            end
            OPC_ANDI: begin
                ctrl_d.alu_op  = ALU_AND;
                ctrl_d.opb_sel = OPB_ZEXT;
                ctrl_d.res_sel = RES_ALU;
            end
            OPC_XORI: begin
                ctrl_d.alu_op  = ALU_XOR;
                ctrl_d.opb_sel = OPB_ZEXT;
                ctrl_d.res_sel = RES_ALU;
            end
            OPC_BEQ:  ctrl_d.npc_sel = NPC_EQ;
            OPC_BNE:  ctrl_d.npc_sel = NPC_NE;
            OPC_BGTZ: ctrl_d.npc_sel = NPC_GTZ;
            OPC_JABS: ctrl_d.npc_sel = NPC_JABS;
            OPC_LOAD: begin
                ctrl_d.opb_sel = OPB_SEXT;
                ctrl_d.res_sel = RES_LOAD;
                ctrl_d.mem_rd  = 1'b1;
            end
            OPC_STORE: begin
                ctrl_d.opb_sel = OPB_SEXT;
                ctrl_d.mem_wr  = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/exec_alu.sv
module exec_alu
    import exec_pkg::*;
(
    input  alu_op_e            op,
    input  logic [XLEN-1:0]    a,
    input  logic [XLEN-1:0]    b,
    input  logic [SHAMT_W-1:0] shamt,
    output logic [XLEN-1:0]    y_d
);
    always_comb begin
        unique case (op)
            ALU_ADD: y_d = a + b;
            ALU_SUB: y_d = a - b;
            ALU_AND: y_d = a & b;
            ALU_OR:  y_d = a | b;
            ALU_XOR: y_d = a ^ b;
            ALU_NOR: y_d = ~(a | b);
            ALU_SLT: y_d = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SRA: y_d = $unsigned($signed(b) >>> shamt);
            default: y_d = '0;
        endcase
    end
endmodule

// File: rtl/exec_npc.sv
module exec_npc
    import exec_pkg::*;
(
    input  npc_sel_e         sel,
    input  logic [XLEN-1:0]  pc_cur,
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    input  logic [XLEN-1:0]  offset_sext,
    input  logic [TGT_W-1:0] target,
    output logic [XLEN-1:0]  pc_next_d
);
    localparam int HI_W = XLEN - TGT_W - 2;

    logic [XLEN-1:0] seq;
    logic [XLEN-1:0] branch_tgt;
    logic [XLEN-1:0] jump_tgt;
    logic            taken;

    assign seq        = pc_cur + XLEN'(PC_STEP);
    assign branch_tgt = seq + {offset_sext[XLEN-3:0], 2'b00};
    assign jump_tgt   = {seq[XLEN-1 -: HI_W], target, 2'b00};

    always_comb begin
        unique case (sel)
            NPC_EQ:  taken = (opa == opb);
            NPC_NE:  taken = (opa != opb);
            NPC_GTZ: taken = !opa[XLEN-1] && (opa != '0);
            default: taken = 1'b0;
        endcase
    end

    always_comb begin
        unique case (sel)
            NPC_JABS: pc_next_d = jump_tgt;
            NPC_JREG: pc_next_d = opa;
            NPC_EQ, NPC_NE, NPC_GTZ: pc_next_d = taken ? branch_tgt : seq;
            default:  pc_next_d = seq;
        endcase
    end
endmodule

// File: rtl/exec_comb_unit.sv
module exec_comb_unit
    import exec_pkg::*;
(
    input  logic [31:0] insn,
    input  logic [31:0] pc_cur,
    input  logic [31:0] opa,
    input  logic [31:0] opb,
    input  logic [31:0] rd_data,
    output logic [31:0] rd_addr,
    output logic        rd_en,
    output logic [31:0] wr_data,
    output logic [31:0] wr_addr,
    output logic        wr_en,
    output logic [31:0] result,
    output logic [31:0] pc_next
);
    ctrl_t           ctrl_d;
    logic [XLEN-1:0] imm_sext;
    logic [XLEN-1:0] imm_zext;
    logic [XLEN-1:0] alu_b;
    logic [XLEN-1:0] alu_y_d;
    logic [XLEN-1:0] npc_d;
    exec_out_t       out_d;

    assign imm_sext = {{(XLEN-IMM_W){insn[IMM_W-1]}}, insn[IMM_W-1:0]};
    assign imm_zext = {{(XLEN-IMM_W){1'b0}}, insn[IMM_W-1:0]};

    exec_decode u_decode (
        .insn   (insn),
        .ctrl_d (ctrl_d)
    );

    always_comb begin
        unique case (ctrl_d.opb_sel)
            OPB_SEXT: alu_b = imm_sext;
            OPB_ZEXT: alu_b = imm_zext;
            default:  alu_b = opb;
        endcase
    end

    exec_alu u_alu (
        .op    (ctrl_d.alu_op),
        .a     (opa),
        .b     (alu_b),
        .shamt (insn[10:6]),
        .y_d   (alu_y_d)
    );

    exec_npc u_npc (
        .sel         (ctrl_d.npc_sel),
        .pc_cur      (pc_cur),
        .opa         (opa),
        .opb         (opb),
        .offset_sext (imm_sext),
        .target      (insn[TGT_W-1:0]),
        .pc_next_d   (npc_d)
    );

    always_comb begin
        out_d         = '0;
        out_d.rd_en   = ctrl_d.mem_rd;
        out_d.wr_en   = ctrl_d.mem_wr;
        if (ctrl_d.mem_rd) out_d.rd_addr = alu_y_d;
        if (ctrl_d.mem_wr) begin
            out_d.wr_addr = alu_y_d;
            out_d.wr_data = opb;
        end
        unique case (ctrl_d.res_sel)
            RES_ALU:  out_d.result = alu_y_d;
            RES_LOAD: out_d.result = rd_data;
            default:  out_d.result = '0;
        endcase
    end

    assign rd_addr = out_d.rd_addr;
    assign rd_en   = out_d.rd_en;
    assign wr_data = out_d.wr_data;
    assign wr_addr = out_d.wr_addr;
    assign wr_en   = out_d.wr_en;
    assign result  = out_d.result;
    assign pc_next = npc_d;
endmodule

// File: rtl/exec_comb_unit_chk.sv
module exec_comb_unit_chk (
    input logic [31:0] insn,
    input logic [31:0] opa,
    input logic [31:0] opb,
    input logic [31:0] rd_data,
    input logic [31:0] rd_addr,
    input logic        rd_en,
    input logic [31:0] wr_data,
    input logic [31:0] wr_addr,
    input logic        wr_en,
    input logic [31:0] result,
    input logic [31:0] pc_next
);
    always_comb begin
        AST_STROBES_EXCLUSIVE: assert (!(rd_en && wr_en)) else $error("both strobes high"); // R11
        AST_RD_ADDR_IDLE: assert (rd_en || rd_addr == 32'h0) else $error("rd_addr not idle"); // R11
        AST_WR_IDLE: assert (wr_en || (wr_addr == 32'h0 && wr_data == 32'h0)) else $error("write side not idle"); // R11
        AST_LOAD_RESULT: assert (!rd_en || result == rd_data) else $error("load result"); // R9
        AST_STORE_DATA: assert (!wr_en || (wr_data == opb && result == 32'h0)) else $error("store data"); // R10
        AST_REG_JUMP: assert (!(insn[31:26] == 6'h00 && insn[5:0] == 6'h08) || pc_next == opa) else $error("register jump"); // R8
        AST_LOAD_ENABLE: assert ((insn[31:26] == 6'h23) == rd_en) else $error("load enable"); // R9
    end
endmodule

bind exec_comb_unit exec_comb_unit_chk u_chk (
    .insn    (insn),
    .opa     (opa),
    .opb     (opb),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .rd_en   (rd_en),
    .wr_data (wr_data),
    .wr_addr (wr_addr),
    .wr_en   (wr_en),
    .result  (result),
    .pc_next (pc_next)
);

// File: tb/exec_comb_unit_bench.sv
`timescale 1ns/1ps
module exec_comb_unit_bench;
    logic        clk = 1'b0;
    logic [31:0] insn, pc_cur, opa, opb, rd_data;
    logic [31:0] rd_addr, wr_data, wr_addr, result, pc_next;
    logic        rd_en, wr_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    exec_comb_unit u_exec_comb_unit (
        .insn(insn), .pc_cur(pc_cur), .opa(opa), .opb(opb), .rd_data(rd_data),
        .rd_addr(rd_addr), .rd_en(rd_en), .wr_data(wr_data), .wr_addr(wr_addr),
        .wr_en(wr_en), .result(result), .pc_next(pc_next)
    );

    // Behavioural reference: expected outputs for one instruction.
    logic [31:0] e_rd_addr, e_wr_data, e_wr_addr, e_result, e_pc_next;
    logic        e_rd_en, e_wr_en;

    task automatic model(input logic [31:0] w, p, a, b, m);
        int unsigned op, fn, sh;
        longint      sa, sb, si;
        longint      simm, zimm;
        logic [31:0] step;
        op   = w >> 26;
        fn   = w & 32'h3F;
        sh   = (w >> 6) & 32'h1F;
        sa   = longint'($signed(a));
        sb   = longint'($signed(b));
        zimm = longint'(w & 32'hFFFF);
        simm = (zimm >= 32768) ? zimm - 65536 : zimm;
        step = p + 32'd4;
        e_rd_addr = 0; e_wr_data = 0; e_wr_addr = 0; e_result = 0;
        e_rd_en = 0; e_wr_en = 0; e_pc_next = step;
        case (op)
            0: case (fn)
                32: e_result = 32'(sa + sb);
                34: e_result = 32'(sa - sb);
                36: e_result = a & b;
                37: e_result = a | b;
                38: e_result = a ^ b;
                39: e_result = ~(a | b);
                42: e_result = (sa < sb) ? 32'd1 : 32'd0;
                3: begin
                    si = sb;
                    for (int k = 0; k < int'(sh); k++) si = (si < 0) ? (si - 1) / 2 : si / 2;
                    e_result = 32'(si);
                end
                8: e_pc_next = a;
                default: ;
            endcase
            8:  e_result = 32'(sa + simm);
            10: e_result = (sa < simm) ? 32'd1 : 32'd0;
            12: e_result = a & 32'(zimm);
            14: e_result = a ^ 32'(zimm);
            4:  if (a == b) e_pc_next = 32'(longint'(step) + simm * 4);
            5:  if (a != b) e_pc_next = 32'(longint'(step) + simm * 4);
            7:  if (sa > 0) e_pc_next = 32'(longint'(step) + simm * 4);
            2:  e_pc_next = (step & 32'hF000_0000) | ((w & 32'h03FF_FFFF) << 2);
            35: begin e_rd_en = 1; e_rd_addr = 32'(sa + simm); e_result = m; end
            43: begin e_wr_en = 1; e_wr_addr = 32'(sa + simm); e_wr_data = b; end
            default: ;
        endcase
    endtask

    task automatic apply(input logic [31:0] w, p, a, b, m, input string tag);
        @(posedge clk);
        #1;
        insn = w; pc_cur = p; opa = a; opb = b; rd_data = m;
        model(w, p, a, b, m);
        @(negedge clk);
        checks++;
        if ({rd_addr, rd_en, wr_data, wr_addr, wr_en, result, pc_next} !==
            {e_rd_addr, e_rd_en, e_wr_data, e_wr_addr, e_wr_en, e_result, e_pc_next}) begin
            errors++;
            $display("FAIL %s insn=%h: got ra=%h re=%b wd=%h wa=%h we=%b res=%h npc=%h exp ra=%h re=%b wd=%h wa=%h we=%b res=%h npc=%h",
                     tag, w, rd_addr, rd_en, wr_data, wr_addr, wr_en, result, pc_next,
                     e_rd_addr, e_rd_en, e_wr_data, e_wr_addr, e_wr_en, e_result, e_pc_next);
        end
    endtask

    function automatic logic [31:0] rt(input logic [5:0] fn, input logic [4:0] sh);
        return {6'h00, 5'd1, 5'd2, 5'd3, sh, fn};
    endfunction

    function automatic logic [31:0] it(input logic [5:0] op, input logic [15:0] imm);
        return {op, 5'd1, 5'd2, imm};
    endfunction

    initial begin
        insn = 0; pc_cur = 0; opa = 0; opb = 0; rd_data = 0;
        // Idle word: opcode 0, function 0 is not listed
        apply(32'h0, 32'h0000_1000, 32'h5, 32'h7, 32'h9, "R12 idle word");
        apply(rt(6'h20, 0), 32'h100, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R1 add wrap");
        apply(rt(6'h20, 0), 32'h100, 32'h7FFF_FFFF, 32'h1, 0, "R1 add overflow no trap");
        apply(rt(6'h22, 0), 32'h100, 32'h0, 32'h1, 0, "R1 sub borrow");
        apply(rt(6'h24, 0), 32'h100, 32'hAAAA_5555, 32'hFF00_FF00, 0, "R2 and");
        apply(rt(6'h25, 0), 32'h100, 32'h3, 32'h5, 0, "R2 or");
        apply(rt(6'h26, 0), 32'h100, 32'h3, 32'h5, 0, "R2 xor");
        apply(rt(6'h27, 0), 32'h100, 32'h3, 32'h5, 0, "R2 nor");
        apply(rt(6'h2A, 0), 32'h100, 32'hFFFF_FFFF, 32'h1, 0, "R3 slt negative below");
        apply(rt(6'h2A, 0), 32'h100, 32'h1, 32'h8000_0000, 0, "R3 slt positive above min");
        apply(it(6'h0A, 16'hFFFF), 32'h100, 32'hFFFF_FFFE, 0, 0, "R3 slti signext");
        apply(it(6'h0A, 16'h0003), 32'h100, 32'h5, 0, 0, "R3 slti false");
        apply(rt(6'h03, 7), 32'h100, 32'h1234, 32'h8000_00FF, 0, "R4 sra negative");
        apply(rt(6'h03, 31), 32'h100, 32'h0, 32'h7FFF_FFFF, 0, "R4 sra full positive");
        apply(it(6'h08, 16'h8000), 32'h100, 32'h10, 0, 0, "R5 addi signext");
        apply(it(6'h0C, 16'hFFFF), 32'h100, 32'hDEAD_BEEF, 0, 0, "R5 andi zeroext");
        apply(it(6'h0E, 16'h8001), 32'h100, 32'hFFFF_0000, 0, 0, "R5 xori zeroext");
        apply(it(6'h04, 16'h1000), 32'h200, 32'h1234, 32'h1234, 0, "R6 beq taken");
        apply(it(6'h04, 16'h1000), 32'h200, 32'h1234, 32'hABCD, 0, "R6 beq not taken");
        apply(it(6'h05, 16'hFFFC), 32'h200, 32'h100, 32'h200, 0, "R6 bne backward taken");
        apply(it(6'h05, 16'h0010), 32'h200, 32'h300, 32'h300, 0, "R6 bne not taken");
        apply(it(6'h07, 16'h0020), 32'h400, 32'h0DAD_BEEF, 0, 0, "R7 bgtz positive");
        apply(it(6'h07, 16'h0020), 32'h400, 32'h7FFF_FFFF, 0, 0, "R7 bgtz max");
        apply(it(6'h07, 16'h0020), 32'h400, 32'h0, 0, 0, "R7 bgtz zero");
        apply(it(6'h07, 16'h0020), 32'h400, 32'h8000_0000, 0, 0, "R7 bgtz min");
        apply({6'h02, 26'h0010000}, 32'hAFFF_FFFC, 0, 0, 0, "R8 jump region of pc+4");
        apply(rt(6'h08, 0), 32'h400, 32'h0000_1000, 32'h55, 0, "R8 register jump");
        apply(it(6'h23, 16'h0007), 32'h400, 32'h1000, 32'h99, 32'hABCD_ABCD, "R9 load");
        apply(it(6'h23, 16'hFFFC), 32'h400, 32'h1000, 32'h99, 32'h1357_9BDF, "R9 load negative offset");
        apply(it(6'h2B, 16'h0007), 32'h400, 32'h1000, 32'hDEAD_DEAD, 32'h1, "R10 R13 store");
        apply({6'h3F, 26'h3FF_FFFF}, 32'h400, 32'h1, 32'h2, 32'h3, "R12 R11 unknown opcode");
        apply(rt(6'h21, 0), 32'h400, 32'h1, 32'h2, 32'h3, "R12 unknown function");
        apply(it(6'h04, 16'h0001), 32'h400, 32'h9, 32'h9, 32'h7, "R13 R11 branch result zero");
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] w;
            logic [5:0]  ops [11];
            logic [5:0]  fns [9];
            ops = '{6'h00, 6'h02, 6'h04, 6'h05, 6'h07, 6'h08, 6'h0A, 6'h0C, 6'h0E, 6'h23, 6'h2B};
            fns = '{6'h03, 6'h08, 6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h27, 6'h2A};
            w = $urandom;
            if (n % 4 != 0) w[31:26] = ops[$urandom % 11];
            if (w[31:26] == 6'h00 && n % 8 != 0) w[5:0] = fns[$urandom % 9];
            apply(w, $urandom, (n % 5 == 0) ? 32'h0 : $urandom, $urandom, $urandom,
                  "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12 R13 random");
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule